// File: doc/BRIEF.md
# Two-Bank SDRAM Access Controller

This block turns single-word read and write requests into command sequences for a single-data-rate SDRAM that has two banks. A client offers a request with a bank, row, column, write word and byte mask on a valid/ready port. The controller opens the row, issues one column access with a burst of one, and closes the row with a single-bank precharge. Only one access is in flight at a time. Read data comes back on a one-cycle valid pulse once the CAS latency has passed.

The CAS latency is a parameter and may be 2 or 3. It selects the matching minimum cycle counts for activate-to-column, active time, precharge time and row cycle. Write recovery before precharge and the read data window are handled as separate rules. The pads, refresh and power-up sequencing live outside this block, so the data bus is split into an output word, an output enable and an input word.

Top module: `sdram_closed_page_ctrl`

## Requirements
- R1: After reset the command pins carry no-operation (ras_n, cas_n, we_n = 1,1,1), DQM is all ones, the data output enable and rd_valid are low, and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high, and bank activate (0,1,1) with the request's row on the address and its bank on the bank pin follows in the next cycle.
- R3: The column command (write 1,0,0 or read 1,0,1) comes exactly T_RCD cycles after the activate (3 at CAS latency 3, 2 at CAS latency 2). The column sits zero-extended in the low address bits, and address bit 10, the auto-precharge flag, is low.
- R4: A single-bank precharge (0,1,0, address bit 10 low) comes max(T_RAS, T_RCD+2) cycles after the activate (6 at CAS latency 3, 5 at 2). That makes it at least 2 cycles after the last write data.
- R5: The next activate comes no sooner than max(T_RC, precharge offset + T_RP) cycles after the previous one (9 at CAS latency 3, 7 at 2). req_ready is high exactly from the cycle before that point until a request is taken.
- R6: The write word is driven with the output enable high only in the write command cycle. In that cycle DQM carries the request's byte mask, and a mask bit of 1 leaves that byte of memory unchanged.
- R7: DQM is all zeros from the read command cycle through the cycle CAS-latency cycles later. Outside that window and outside a write command cycle it is all ones.
- R8: rd_valid is a one-cycle pulse CAS latency + 1 cycles after the read command cycle. rd_data holds the data-bus input word sampled at the edge that ends the cycle CAS-latency cycles after the read command.
- R9: Bank select 0 addresses bank A and 1 addresses bank B. The same bank value is driven on the activate, column and precharge of one access.
- R10: Every other cycle carries the no-operation command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 1 | Bank select of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_wdata | input | DATA_W | Write word |
| req_wmask | input | DATA_W/8 | Byte mask, 1 keeps the byte |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | DATA_W | Read word |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_bank | output | 1 | Bank select |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | DATA_W/8 | Byte mask / output disable |
| sd_dq_out | output | DATA_W | Data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Data from the memory |

## Verification
The hardest case to reach from the ports is a request taken in the very first cycle req_ready comes back. That case tests the row-cycle and precharge spacing at their minimum, so the stimulus holds req_valid high through a run of mixed reads and writes across both banks. A second hard point is proving that a masked byte was not written. For this the bench writes with a partial or full mask and then reads the same word back. Its memory model and its expected data are built only from the commands and requests it sees.

// File: rtl/sdram_closed_page_ctrl.sv
module sdram_closed_page_ctrl #(
  parameter int CAS_LAT = 3,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int MASK_W  = DATA_W / 8,
  parameter int AP_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MASK_W-1:0] req_wmask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_bank,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [MASK_W-1:0] sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int T_RCD = (CAS_LAT == 3) ? 3 : 2;
  localparam int T_RAS = (CAS_LAT == 3) ? 6 : 5;
  localparam int T_RP  = (CAS_LAT == 3) ? 3 : 2;
  localparam int T_RC  = (CAS_LAT == 3) ? 9 : 7;
  localparam int T_WR  = 2;
  localparam int T_PRE = (T_RAS > T_RCD + T_WR) ? T_RAS : T_RCD + T_WR;
  localparam int T_CYC = (T_RC > T_PRE + T_RP) ? T_RC : T_PRE + T_RP;
  localparam int CW    = $clog2(T_CYC + 1);

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [2:0]        cmd;
  logic              h_write;
  logic [COL_W-1:0]  h_col;
  logic [DATA_W-1:0] h_data;
  logic [MASK_W-1:0] h_mask;
  logic [MASK_W-1:0] wr_mask;
  logic [CAS_LAT:0]  rd_sr;

  wire          accept   = req_valid && req_ready;
  wire [CW-1:0] nxt      = cnt + 1'b1;
  wire          at_col   = busy && !accept && (nxt == CW'(T_RCD));
  wire          at_pre   = busy && !accept && (nxt == CW'(T_PRE));
  wire          issue_rd = at_col && !h_write;
  wire [ROW_W-1:0] col_addr = ROW_W'(h_col);

  assign req_ready = !busy || (cnt == CW'(T_CYC - 1));
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm = (cmd == C_WR) ? wr_mask : ((|rd_sr) ? '0 : '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cmd       <= C_NOP;
      sd_bank   <= 1'b0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wr_mask   <= '1;
      h_write   <= 1'b0;
      h_col     <= '0;
      h_data    <= '0;
      h_mask    <= '1;
      rd_sr     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_sr    <= {rd_sr[CAS_LAT-1:0], issue_rd};
      rd_valid <= rd_sr[CAS_LAT];
      if (rd_sr[CAS_LAT]) rd_data <= sd_dq_in;
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= '0;
        cmd     <= C_ACT;
        sd_bank <= req_bank;
        sd_addr <= req_row;
        h_write <= req_write;
        h_col   <= req_col;
        h_data  <= req_wdata;
        h_mask  <= req_wmask;
      end else if (busy) begin
        cnt <= nxt;
        if (cnt == CW'(T_CYC - 1)) busy <= 1'b0;
        if (at_col) begin
          cmd     <= h_write ? C_WR : C_RD;
          sd_addr <= col_addr;
          if (h_write) begin
            sd_dq_oe  <= 1'b1;
            sd_dq_out <= h_data;
            wr_mask   <= h_mask;
          end
        end
        if (at_pre) begin
          cmd     <= C_PRE;
          sd_addr <= '0;
        end
      end
    end
  end
endmodule

module sdram_cp_checker #(
  parameter int CAS_LAT = 3,
  parameter int ROW_W   = 12,
  parameter int MASK_W  = 2,
  parameter int AP_BIT  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              bank,
  input logic [ROW_W-1:0]  addr,
  input logic [MASK_W-1:0] dqm,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic              req_valid,
  input logic              req_ready
);
  localparam int K_RCD = (CAS_LAT == 3) ? 3 : 2;
  localparam int K_RAS = (CAS_LAT == 3) ? 6 : 5;
  localparam int K_RP  = (CAS_LAT == 3) ? 3 : 2;
  localparam int K_RC  = (CAS_LAT == 3) ? 9 : 7;

  wire [2:0] c = {ras_n, cas_n, we_n};
  wire is_act = (c == 3'b011);
  wire is_pre = (c == 3'b010);
  wire is_wr  = (c == 3'b100);
  wire is_col = is_wr || (c == 3'b101);

  logic [7:0] since_act, since_pre, since_wr;
  logic       act_bank;

  function automatic logic [7:0] sat(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_pre <= 8'hFF;
      since_wr  <= 8'hFF;
      act_bank  <= 1'b0;
    end else begin
      since_act <= is_act ? 8'd1 : sat(since_act);
      since_pre <= is_pre ? 8'd1 : sat(since_pre);
      since_wr  <= is_wr  ? 8'd1 : sat(since_wr);
      if (is_act) act_bank <= bank;
    end
  end

  a_r2_act_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_act);
  a_r3_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act >= 8'(K_RCD));
  a_r3_no_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !addr[AP_BIT]);
  a_r4_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_act >= 8'(K_RAS)) && (since_wr >= 8'd2) && !addr[AP_BIT]);
  a_r5_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_act >= 8'(K_RC)) && (since_pre >= 8'(K_RP)));
  a_r6_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == is_wr);
  a_r7_dqm_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (dqm == '1));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r9_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col || is_pre) |-> bank == act_bank);
endmodule

bind sdram_closed_page_ctrl sdram_cp_checker #(
  .CAS_LAT(CAS_LAT), .ROW_W(ROW_W), .MASK_W(MASK_W), .AP_BIT(AP_BIT)
) u_cp_checker (
  .clk(clk), .rst_n(rst_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
  .bank(sd_bank), .addr(sd_addr), .dqm(sd_dqm), .dq_oe(sd_dq_oe),
  .rd_valid(rd_valid), .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/test_sdram_closed_page_ctrl.sv
module test_sdram_closed_page_ctrl;
  localparam int CL = 3, ROW_W = 12, COL_W = 8, DATA_W = 16, MASK_W = 2, AP = 10;
  localparam int B_RCD = (CL == 3) ? 3 : 2;
  localparam int B_RAS = (CL == 3) ? 6 : 5;
  localparam int B_RP  = (CL == 3) ? 3 : 2;
  localparam int B_RC  = (CL == 3) ? 9 : 7;
  localparam int B_PRE = (B_RAS > B_RCD + 2) ? B_RAS : B_RCD + 2;
  localparam int B_CYC = (B_RC > B_PRE + B_RP) ? B_RC : B_PRE + B_RP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_bank = 0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [MASK_W-1:0] req_wmask = '0;
  logic req_ready, rd_valid, sd_ras_n, sd_cas_n, sd_we_n, sd_bank, sd_dq_oe;
  logic [DATA_W-1:0] rd_data, sd_dq_out;
  logic [DATA_W-1:0] sd_dq_in = 16'hDEAD;
  logic [ROW_W-1:0] sd_addr;
  logic [MASK_W-1:0] sd_dqm;

  always #4 clk = ~clk;

  sdram_closed_page_ctrl #(.CAS_LAT(CL), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .MASK_W(MASK_W), .AP_BIT(AP)) i_sdram_closed_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_wmask(req_wmask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_bank(sd_bank),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int n_tests = 0, n_fail = 0, cyc = 0, last_act = -1000;
  bit done = 0;

  logic [2:0]        e_cmd  [int];
  logic              e_ba   [int];
  logic [ROW_W-1:0]  e_addr [int];
  logic [MASK_W-1:0] e_mask [int];
  logic [DATA_W-1:0] e_dout [int];
  bit                e_rwin [int];
  logic [DATA_W-1:0] e_rdv  [int];
  logic [DATA_W-1:0] shadow [int];
  logic [DATA_W-1:0] dev    [int];
  logic [DATA_W-1:0] due    [int];
  logic [ROW_W-1:0]  dev_row [2];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int key(input logic b, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return {11'd0, b, r, c};
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] d, input logic [MASK_W-1:0] m);
    logic [DATA_W-1:0] v = old;
    for (int b = 0; b < MASK_W; b++) if (!m[b]) v[8*b +: 8] = d[8*b +: 8];
    return v;
  endfunction

  always @(negedge clk) begin
    logic [2:0] cm, ec;
    logic [MASK_W-1:0] edqm;
    string rq;
    int k;
    if (rst_n) begin
      cyc++;
      cm = {sd_ras_n, sd_cas_n, sd_we_n};
      // memory device model
      if (cm == 3'b011) dev_row[sd_bank] = sd_addr;
      if (cm == 3'b100) begin
        k = key(sd_bank, dev_row[sd_bank], sd_addr[COL_W-1:0]);
        dev[k] = merge(dev.exists(k) ? dev[k] : '0, sd_dq_out, sd_dqm);
      end
      if (cm == 3'b101) begin
        k = key(sd_bank, dev_row[sd_bank], sd_addr[COL_W-1:0]);
        due[cyc + CL] = dev.exists(k) ? dev[k] : '0;
      end
      sd_dq_in = due.exists(cyc) ? due[cyc] : 16'hDEAD;
      // reference comparison
      ec = e_cmd.exists(cyc) ? e_cmd[cyc] : 3'b111;
      case (ec)
        3'b011: rq = "R2";
        3'b100, 3'b101: rq = "R3";
        3'b010: rq = "R4";
        default: rq = "R10";
      endcase
      chk(cm == ec, rq, "command", cm, ec);
      if (ec != 3'b111) begin
        chk(sd_addr == e_addr[cyc], rq, "address", sd_addr, e_addr[cyc]);
        chk(sd_bank == e_ba[cyc], "R9", "bank", sd_bank, e_ba[cyc]);
      end
      edqm = (ec == 3'b100) ? e_mask[cyc] : (e_rwin.exists(cyc) ? '0 : '1);
      chk(sd_dqm == edqm, (ec == 3'b100) ? "R6" : "R7", "dqm", sd_dqm, edqm);
      chk(sd_dq_oe == (ec == 3'b100), "R6", "dq_oe", sd_dq_oe, ec == 3'b100);
      if (ec == 3'b100) chk(sd_dq_out == e_dout[cyc], "R6", "dq_out", sd_dq_out, e_dout[cyc]);
      chk(rd_valid == e_rdv.exists(cyc), "R8", "rd_valid", rd_valid, e_rdv.exists(cyc));
      if (e_rdv.exists(cyc)) chk(rd_data == e_rdv[cyc], "R8", "rd_data", rd_data, e_rdv[cyc]);
      chk(req_ready == (cyc >= last_act + B_CYC - 1), "R5", "req_ready", req_ready,
          cyc >= last_act + B_CYC - 1);
      if (req_valid && req_ready) begin
        int a, c, p, sk;
        a = cyc + 1; c = a + B_RCD; p = a + B_PRE;
        last_act = a;
        e_cmd[a] = 3'b011; e_ba[a] = req_bank; e_addr[a] = req_row;
        e_cmd[c] = req_write ? 3'b100 : 3'b101; e_ba[c] = req_bank;
        e_addr[c] = ROW_W'(req_col);
        sk = key(req_bank, req_row, req_col);
        if (req_write) begin
          e_mask[c] = req_wmask; e_dout[c] = req_wdata;
          shadow[sk] = merge(shadow.exists(sk) ? shadow[sk] : '0, req_wdata, req_wmask);
        end else begin
          for (int j = 0; j <= CL; j++) e_rwin[c + j] = 1;
          e_rdv[c + CL + 1] = shadow.exists(sk) ? shadow[sk] : '0;
        end
        e_cmd[p] = 3'b010; e_ba[p] = req_bank; e_addr[p] = '0;
      end
    end
  end

  task automatic send(input bit w, input bit b, input logic [ROW_W-1:0] r,
                      input logic [COL_W-1:0] c, input logic [DATA_W-1:0] d,
                      input logic [MASK_W-1:0] m);
    bit acc = 0;
    req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c;
    req_wdata = d; req_wmask = m;
    while (!acc) begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "cmd", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(sd_dqm == '1 && !sd_dq_oe, "R1", "dqm/oe", {sd_dqm, sd_dq_oe}, 6);
    chk(!rd_valid && req_ready, "R1", "valid/ready", {rd_valid, req_ready}, 1);
    @(posedge clk); #1;
    send(1, 0, 12'h005, 8'h03, 16'hA5A5, 2'b00); idle(4);
    send(0, 0, 12'h005, 8'h03, 16'h0, 2'b00);    idle(6);
    send(1, 1, 12'h005, 8'h03, 16'h1234, 2'b00); idle(2);
    send(0, 0, 12'h005, 8'h03, 16'h0, 2'b00);    // R9 bank A untouched
    send(0, 1, 12'h005, 8'h03, 16'h0, 2'b00);    idle(3);
    send(1, 0, 12'h005, 8'h03, 16'hFFFF, 2'b01); // R6 low byte kept
    send(0, 0, 12'h005, 8'h03, 16'h0, 2'b00);
    send(1, 0, 12'h005, 8'h03, 16'h0011, 2'b10); // R6 high byte kept
    send(0, 0, 12'h005, 8'h03, 16'h0, 2'b00);
    send(1, 0, 12'h005, 8'h03, 16'h7777, 2'b11); // R6 fully masked: no change
    send(0, 0, 12'h005, 8'h03, 16'h0, 2'b00);
    for (int i = 0; i < 6; i++) begin            // R5 back-to-back at minimum spacing
      send(1, i[0], 12'hFFF - 12'(i), 8'hFF - 8'(i), 16'h1000 + 16'(i * 37), 2'b00);
      send(0, i[0], 12'hFFF - 12'(i), 8'hFF - 8'(i), 16'h0, 2'b00);
    end
    send(0, 1, 12'h0AA, 8'h00, 16'h0, 2'b00);    // R8 unwritten word reads zero
    idle(30);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule